// File: doc/BRIEF.md
# Signed Integer to Floating-Point Converter

This block turns a signed two's-complement integer into an IEEE 754 binary floating-point value. The integer is taken from the low 32 or 64 bits of a 128-bit source vector. The result is half, single or double precision, and the block writes it into the lowest element of a 128-bit destination vector. Two select inputs choose the conversion variant. Only four source/result pairings are legal. Any other setting is reported as an undefined encoding, and in that case the old destination passes through unchanged.

Rounding follows a two-bit mode input. A merge input decides what happens to the destination bits above the new element: they either keep the previous destination contents or are cleared. The block reports two status flags, inexact and overflow. Each operation is presented with a valid strobe, and its result appears one clock later.

Top module: `sitofp_convert`

## Requirements
- R1: Legal variants are (sizeSel, typeSel) = (0,11) 32-bit to half, (0,01) 32-bit to double, (1,11) 64-bit to half and (1,00) 64-bit to single. Any other combination sets undefEnc, copies dstOld to dstVec unchanged, and clears both flags.
- R2: The source integer is srcVec[31:0] when sizeSel is 0 and srcVec[63:0] when sizeSel is 1. It is read as signed two's complement. Bits above the selected width have no effect.
- R3: The result occupies dstVec[15:0], [31:0] or [63:0] for half, single or double. Above that element, dstVec equals dstOld when mergeEn is 1 and zero when mergeEn is 0.
- R4: roundMode selects the rounding: 00 nearest with ties to even, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero.
- R5: inexact is 1 exactly when the converted value differs from the source integer.
- R6: A half-precision result whose rounded magnitude exceeds 65504 sets overflow and inexact. The result is infinity in modes 00, in mode 01 for positive inputs and in mode 10 for negative inputs. Otherwise it is ±65504 (exponent field 11110, fraction all ones).
- R7: A zero integer converts to +0.0 with both flags clear.
- R8: The most negative 32-bit and 64-bit integers convert to an exact negative power of two, or are rounded or overflow like any other value.
- R9: outValid is high exactly one cycle after inValid, and the result fields belong to that operation. After reset, outValid, dstVec and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| sizeSel | input | 1 | Integer size: 0 = 32 bits, 1 = 64 bits |
| typeSel | input | 2 | Result type: 00 single, 01 double, 11 half |
| roundMode | input | 2 | Rounding direction |
| mergeEn | input | 1 | 1 keeps dstOld above the element, 0 clears it |
| srcVec | input | 128 | Source vector holding the integer |
| dstOld | input | 128 | Previous destination contents |
| outValid | output | 1 | Result valid, one cycle after inValid |
| dstVec | output | 128 | New destination contents |
| inexact | output | 1 | Rounding discarded nonzero bits |
| overflow | output | 1 | Half-precision range exceeded |
| undefEnc | output | 1 | Illegal variant selected |

## Verification
The only state is the single output register, so any internal fault shows up at the ports in the cycle right after the operation that triggered it. A bad leading-zero count shifts the exponent and scrambles the fraction. A wrong rounding increment shows up at ties and at all-ones significands, where the carry bumps the exponent. A decode fault appears as a wrong element width, a lost merge, or a missing undefEnc. The scoreboard compares every result against an integer-arithmetic reference, in all four modes, at ties, at the half-precision limit and at both most negative integers.

// File: rtl/sitofp_pkg.sv
package sitofp_pkg;

  localparam int MAG_W = 64;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_NONE   = 2'b10,
    FMT_HALF   = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_UP   = 2'b01,
    RND_DOWN = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef struct packed {
    logic legal;
    logic src64;
    fmt_e fmt;
  } cvtCtrl_t;

  // lane 0 half, lane 1 single, lane 2 double
  localparam int LANES = 3;

  function automatic int laneMant(input int idx);
    return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
  endfunction

  function automatic int laneExp(input int idx);
    return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
  endfunction

  function automatic logic [5:0] countLeadZeros(input logic [MAG_W-1:0] v);
    logic [5:0] cnt;
    logic       seen;
    cnt  = '0;
    seen = 1'b0;
    for (int i = MAG_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) cnt = cnt + 6'd1;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/sitofp_ctrl.sv
module sitofp_ctrl
  import sitofp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       sizeSel,
  input  logic [1:0] typeSel,
  output cvtCtrl_t   ctrl,
  output logic       outValid
);

  always_comb begin
    ctrl.src64 = sizeSel;
    ctrl.fmt   = fmt_e'(typeSel);
    unique case ({sizeSel, typeSel})
      3'b0_11, 3'b0_01, 3'b1_11, 3'b1_00: ctrl.legal = 1'b1;
      default:                            ctrl.legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/sitofp_round.sv
module sitofp_round
  import sitofp_pkg::*;
#(
  parameter int MANT_W = 10,
  parameter int EXP_W  = 5
) (
  input  logic             sign,
  input  logic [MAG_W-1:0] norm,
  input  logic [5:0]       expUnb,
  input  logic [1:0]       roundMode,
  output logic [MAG_W-1:0] fpBits,
  output logic             inexact,
  output logic             overflow
);

  localparam int SH   = MAG_W - 1 - MANT_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [SH-1:0] HALF_PT = {1'b1, {(SH-1){1'b0}}};

  logic [MANT_W:0]   kept;
  logic [SH-1:0]     rem;
  logic              incr;
  logic [MANT_W+1:0] sum;
  logic              carry;
  logic [MANT_W-1:0] frac;
  logic [6:0]        expFin;
  logic              toInf;
  logic [EXP_W-1:0]  expField;

  assign kept = norm[MAG_W-1:SH];
  assign rem  = norm[SH-1:0];

  always_comb begin
    unique case (rnd_e'(roundMode))
      RND_NEAR: incr = (rem > HALF_PT) || ((rem == HALF_PT) && kept[0]);
      RND_UP:   incr = !sign && (rem != '0);
      RND_DOWN: incr = sign && (rem != '0);
      default:  incr = 1'b0;
    endcase
  end

  assign sum      = {1'b0, kept} + {{(MANT_W+1){1'b0}}, incr};
  assign carry    = sum[MANT_W+1];
  assign frac     = carry ? '0 : sum[MANT_W-1:0];
  assign expFin   = {1'b0, expUnb} + {6'd0, carry};
  assign overflow = int'(expFin) > BIAS;
  assign inexact  = (rem != '0) || overflow;
  assign toInf    = (rnd_e'(roundMode) == RND_NEAR) ||
                    ((rnd_e'(roundMode) == RND_UP) && !sign) ||
                    ((rnd_e'(roundMode) == RND_DOWN) && sign);
  assign expField = EXP_W'(expFin) + EXP_W'(BIAS);

  always_comb begin
    if (!overflow)
      fpBits = MAG_W'({sign, expField, frac});
    else if (toInf)
      fpBits = MAG_W'({sign, {EXP_W{1'b1}}, {MANT_W{1'b0}}});
    else
      fpBits = MAG_W'({sign, {{(EXP_W-1){1'b1}}, 1'b0}, {MANT_W{1'b1}}});
  end

endmodule

// File: rtl/sitofp_datapath.sv
module sitofp_datapath
  import sitofp_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  cvtCtrl_t         ctrl,
  input  logic [1:0]       roundMode,
  input  logic             mergeEn,
  input  logic [MAG_W-1:0] srcLow,
  input  logic [VEC_W-1:0] dstOld,
  output logic [VEC_W-1:0] dstVec,
  output logic             inexact,
  output logic             overflow,
  output logic             undefEnc
);

  localparam int HALF_W   = 16;
  localparam int SINGLE_W = 32;
  localparam int DOUBLE_W = 64;

  logic [MAG_W-1:0] srcInt, mag, norm;
  logic             sign, isZero;
  logic [5:0]       lz, expUnb;
  logic [MAG_W-1:0] laneBits [LANES];
  logic [LANES-1:0] laneInx, laneOvf;
  logic [VEC_W-1:0] nextDst;
  logic             nextInx, nextOvf;
  logic             unusedLaneHigh;

  assign srcInt = ctrl.src64 ? srcLow : {{32{srcLow[31]}}, srcLow[31:0]};
  assign sign   = srcInt[MAG_W-1];
  assign mag    = sign ? (~srcInt + 1'b1) : srcInt;
  assign isZero = (mag == '0);
  assign lz     = countLeadZeros(mag);
  assign norm   = mag << lz;
  assign expUnb = 6'(MAG_W - 1) - lz;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    sitofp_round #(.MANT_W(laneMant(g)), .EXP_W(laneExp(g))) round_i (
      .sign(sign), .norm(norm), .expUnb(expUnb), .roundMode(roundMode),
      .fpBits(laneBits[g]), .inexact(laneInx[g]), .overflow(laneOvf[g])
    );
  end

  assign unusedLaneHigh = ^{laneBits[0][MAG_W-1:HALF_W], laneBits[1][MAG_W-1:SINGLE_W]};

  always_comb begin
    nextDst = dstOld;
    nextInx = 1'b0;
    nextOvf = 1'b0;
    if (ctrl.legal) begin
      nextDst = mergeEn ? dstOld : '0;
      unique case (ctrl.fmt)
        FMT_HALF: begin
          nextDst[HALF_W-1:0] = isZero ? '0 : laneBits[0][HALF_W-1:0];
          nextInx = !isZero && laneInx[0];
          nextOvf = !isZero && laneOvf[0];
        end
        FMT_SINGLE: begin
          nextDst[SINGLE_W-1:0] = isZero ? '0 : laneBits[1][SINGLE_W-1:0];
          nextInx = !isZero && laneInx[1];
        end
        default: begin
          nextDst[DOUBLE_W-1:0] = isZero ? '0 : laneBits[2][DOUBLE_W-1:0];
          nextInx = !isZero && laneInx[2];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstVec   <= '0;
      inexact  <= 1'b0;
      overflow <= 1'b0;
      undefEnc <= 1'b0;
    end else begin
      dstVec   <= nextDst;
      inexact  <= nextInx;
      overflow <= nextOvf;
      undefEnc <= !ctrl.legal;
    end
  end

  assert_undef_keeps_dst_R1: assert property (@(posedge clk) disable iff (!rstN)
    undefEnc |-> (dstVec == $past(dstOld)) && !inexact && !overflow);
  assert_merge_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.legal && !mergeEn && ctrl.fmt == FMT_HALF) |-> dstVec[VEC_W-1:HALF_W] == '0);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> inexact && ($past(ctrl.fmt) == FMT_HALF));
  assert_zero_positive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.legal && srcInt == '0) |-> (dstVec[HALF_W-1:0] == '0) && !inexact);

endmodule

// File: rtl/sitofp_convert.sv
module sitofp_convert
  import sitofp_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             sizeSel,
  input  logic [1:0]       typeSel,
  input  logic [1:0]       roundMode,
  input  logic             mergeEn,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstOld,
  output logic             outValid,
  output logic [VEC_W-1:0] dstVec,
  output logic             inexact,
  output logic             overflow,
  output logic             undefEnc
);

  cvtCtrl_t ctrl;
  logic     unusedSrcHigh;

  assign unusedSrcHigh = ^srcVec[VEC_W-1:MAG_W];

  sitofp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel),
    .typeSel(typeSel), .ctrl(ctrl), .outValid(outValid)
  );

  sitofp_datapath #(.VEC_W(VEC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .roundMode(roundMode),
    .mergeEn(mergeEn), .srcLow(srcVec[MAG_W-1:0]), .dstOld(dstOld),
    .dstVec(dstVec), .inexact(inexact), .overflow(overflow), .undefEnc(undefEnc)
  );

endmodule

// File: tb/sitofp_convert_tb.sv
module sitofp_convert_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         sizeSel = 1'b0;
  logic [1:0]   typeSel = 2'b00;
  logic [1:0]   roundMode = 2'b00;
  logic         mergeEn = 1'b0;
  logic [127:0] srcVec = '0;
  logic [127:0] dstOld = '0;
  logic         outValid, inexact, overflow, undefEnc;
  logic [127:0] dstVec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [127:0] dst;
    bit           inx;
    bit           ovf;
    bit           undef;
    string        tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #2 clk = ~clk;

  sitofp_convert dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel),
    .typeSel(typeSel), .roundMode(roundMode), .mergeEn(mergeEn),
    .srcVec(srcVec), .dstOld(dstOld), .outValid(outValid), .dstVec(dstVec),
    .inexact(inexact), .overflow(overflow), .undefEnc(undefEnc)
  );

  function automatic void refConv(input logic [63:0] srcLow, input bit s64,
      input logic [1:0] typ, input logic [1:0] rm,
      output logic [63:0] res, output bit inx, output bit ovf);
    int m, ew, bias, e, sh;
    logic [63:0] sx, mag;
    logic [64:0] lo, rem, halfv;
    bit neg, up, toInf;
    sx   = s64 ? srcLow : {{32{srcLow[31]}}, srcLow[31:0]};
    m    = (typ == 2'b11) ? 10 : (typ == 2'b00) ? 23 : 52;
    ew   = (typ == 2'b11) ? 5 : (typ == 2'b00) ? 8 : 11;
    bias = (1 << (ew - 1)) - 1;
    neg  = sx[63];
    mag  = neg ? (64'd0 - sx) : sx;
    res = '0; inx = 0; ovf = 0; rem = '0;
    if (mag == '0) return;
    e = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) e = i;
    if (e <= m) lo = {1'b0, mag} << (m - e);
    else begin
      sh    = e - m;
      lo    = {1'b0, mag} >> sh;
      rem   = {1'b0, mag} & ((65'd1 << sh) - 65'd1);
      halfv = 65'd1 << (sh - 1);
      case (rm)
        2'b00:   up = (rem > halfv) || (rem == halfv && lo[0]);
        2'b01:   up = !neg && rem != '0;
        2'b10:   up = neg && rem != '0;
        default: up = 0;
      endcase
      lo = lo + 65'(up);
      if (lo[m+1]) begin lo = lo >> 1; e++; end
    end
    inx = (rem != '0);
    if (e > bias) begin
      ovf = 1; inx = 1;
      toInf = (rm == 2'b00) || (rm == 2'b01 && !neg) || (rm == 2'b10 && neg);
      if (toInf) res = (64'(neg) << (ew + m)) | (((64'd1 << ew) - 64'd1) << m);
      else res = (64'(neg) << (ew + m)) | (((64'd1 << ew) - 64'd2) << m) | ((64'd1 << m) - 64'd1);
    end else
      res = (64'(neg) << (ew + m)) | (64'(e + bias) << m) | (lo[63:0] & ((64'd1 << m) - 64'd1));
  endfunction

  task automatic sendOp(input logic [127:0] src, input logic [127:0] old,
      input bit s, input logic [1:0] t, input logic [1:0] rm, input bit mg, input string tag);
    expItem_t it;
    logic [63:0] res, mask;
    bit inx, ovf, legal;
    int w;
    legal = (!s && (t == 2'b11 || t == 2'b01)) || (s && (t == 2'b11 || t == 2'b00));
    it.tag = tag;
    if (!legal) begin
      it.dst = old; it.inx = 0; it.ovf = 0; it.undef = 1;
    end else begin
      refConv(src[63:0], s, t, rm, res, inx, ovf);
      w    = (t == 2'b11) ? 16 : (t == 2'b00) ? 32 : 64;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      it.dst = mg ? old : '0;
      it.dst = (it.dst & ~{64'd0, mask}) | {64'd0, res & mask};
      it.inx = inx; it.ovf = ovf; it.undef = 0;
    end
    @(negedge clk);
    sbQ.push_back(it);
    srcVec = src; dstOld = old; sizeSel = s; typeSel = t;
    roundMode = rm; mergeEn = mg; inValid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops and compares each result
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (sbQ.size() == 0) check(0, "R9 unexpected outValid", 128'd1, 128'd0);
      else begin
        expItem_t e;
        e = sbQ.pop_front();
        check(dstVec == e.dst, {e.tag, " dst"}, dstVec, e.dst);
        check({inexact, overflow, undefEnc} == {e.inx, e.ovf, e.undef}, {e.tag, " flags"},
              128'({inexact, overflow, undefEnc}), 128'({e.inx, e.ovf, e.undef}));
      end
    end
  end

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] old;
    repeat (3) @(negedge clk);
    check(!outValid && dstVec == '0 && !inexact && !overflow && !undefEnc,
          "R9 reset state", dstVec, '0);
    @(negedge clk);
    rstN = 1'b1;
    old = {32'hdead_beef, 32'hcafe_f00d, 32'h1234_5678, 32'h9abc_def0};

    // R1 illegal pairings
    sendOp(rnd128(), old, 0, 2'b00, 2'b00, 1, "R1 32->single illegal");
    sendOp(rnd128(), old, 1, 2'b01, 2'b01, 0, "R1 64->double illegal");
    sendOp(rnd128(), old, 0, 2'b10, 2'b10, 0, "R1 type10 illegal");
    sendOp(rnd128(), old, 1, 2'b10, 2'b11, 1, "R1 type10 64 illegal");
    idle();
    @(negedge clk);
    check(!outValid, "R9 idle no valid", 128'(outValid), 128'd0);

    // R7 zero, all legal variants, upper src garbage
    sendOp({64'hffff_ffff_ffff_ffff, 64'h0}, old, 1, 2'b11, 2'b10, 0, "R7 zero 64->half");
    sendOp({96'hffff, 32'h0}, old, 0, 2'b01, 2'b10, 1, "R7 zero 32->double");
    sendOp({64'h0, 64'hffff_ffff_0000_0000}, old, 0, 2'b11, 2'b01, 0, "R2 R7 upper bits ignored");
    sendOp(128'h0, old, 1, 2'b00, 2'b00, 1, "R7 zero 64->single");

    // R8 most negative integers
    for (int rm = 0; rm < 4; rm++) begin
      sendOp({96'h0, 32'h8000_0000}, old, 0, 2'b01, 2'(rm), 0, "R8 min32 ->double");
      sendOp({64'h0, 64'h8000_0000_0000_0000}, old, 1, 2'b00, 2'(rm), 1, "R8 min64 ->single");
      sendOp({96'h0, 32'h8000_0000}, old, 0, 2'b11, 2'(rm), 0, "R8 R6 min32 ->half");
    end

    // R6 half limits, R4 ties, R5 inexact, all modes and signs
    for (int rm = 0; rm < 4; rm++) begin
      sendOp({96'h0, 32'd65504}, old, 0, 2'b11, 2'(rm), 1, "R6 65504 exact");
      sendOp({96'h0, 32'd65519}, old, 0, 2'b11, 2'(rm), 1, "R6 R5 65519");
      sendOp({96'h0, 32'd65520}, old, 0, 2'b11, 2'(rm), 0, "R6 65520 tie");
      sendOp({96'h0, -32'sd65520}, old, 0, 2'b11, 2'(rm), 0, "R6 -65520 tie");
      sendOp({64'h0, -64'sd100000}, old, 1, 2'b11, 2'(rm), 0, "R6 -100000");
      sendOp({96'h0, 32'd2049}, old, 0, 2'b11, 2'(rm), 0, "R4 2049 tie even down");
      sendOp({96'h0, 32'd2051}, old, 0, 2'b11, 2'(rm), 0, "R4 2051 tie even up");
      sendOp({96'h0, -32'sd2051}, old, 0, 2'b11, 2'(rm), 1, "R4 -2051 tie");
      sendOp({64'h0, 64'h00ff_ffff_ffff_ffff}, old, 1, 2'b00, 2'(rm), 0, "R4 R5 carry single");
      sendOp({64'h0, 64'h0000_0000_0100_0001}, old, 1, 2'b00, 2'(rm), 1, "R4 single tie");
      sendOp({64'h0, 64'h7fff_ffff_ffff_ffff}, old, 1, 2'b00, 2'(rm), 0, "R5 max64 single");
    end
    idle();

    // R3 merge on/off, R2 random with varied magnitudes
    for (int i = 0; i < 600; i++) begin
      logic [127:0] src;
      logic [1:0] t;
      bit s;
      src = rnd128();
      src[63:0] = $signed(src[63:0]) >>> ($urandom % 64);
      s = 1'($urandom);
      t = s ? (($urandom % 2) ? 2'b11 : 2'b00) : (($urandom % 2) ? 2'b11 : 2'b01);
      sendOp(src, rnd128(), s, t, 2'($urandom), 1'($urandom),
             (i % 2) ? "R3 R4 random merge" : "R2 R5 random");
      if (i % 37 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check(sbQ.size() == 0, "R9 all results delivered", 128'(sbQ.size()), 128'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule